// File: doc/BRIEF.md
# Multiplexed Seven-Segment Display Driver

This block drives a row of seven-segment digits that share one set of eight segment lines (a to g plus a decimal point), each digit having its own common-electrode enable. The wiring therefore costs N + 8 lines in place of N times eight. The block lights the digits one after another in a fixed repeating order. While a digit is lit, the shared lines carry that digit's pattern.

The digit values come in as packed BCD words with one decimal-point bit per digit. They are copied into an internal hold register only on a load strobe. Upstream logic can therefore change its data, for example during a count, without disturbing the display. Two active-low overrides act on the live inputs. One lights every segment, for lamp testing. The other turns the whole display off. A brightness value sets how long the enable stays on within each digit's time slot. The final part of every slot is always dark, so no segment pattern carries over into the next digit.

Each digit slot is split into 2^BRIGHT_W steps of STEP_CYC clock cycles. A full refresh of all digits takes NDIG × 2^BRIGHT_W × STEP_CYC cycles. With the default parameters at a 50 MHz clock this gives 250 Hz, well above the 50 Hz needed for a steady image. The outputs are registered. The COMMON_ANODE parameter inverts the segment and enable lines to suit the display type.

Top module: `seg_mux_display`

## Requirements
- R1: While rst is high and on the first edge after it, every segment and enable line is inactive. The hold register resets to code 15 for every digit, with all decimal points clear.
- R2: The hold register copies digits_in and dp_in on a clock edge where load_stb is high. Changes to digits_in and dp_in while load_stb is low have no effect on the display.
- R3: The scan visits digit 0, 1, …, NDIG-1 and then repeats. Each slot lasts 2^BRIGHT_W × STEP_CYC cycles. At most one enable is active at any time. The registered outputs reflect the scan position of the previous clock.
- R4: In normal mode, step s of a slot (steps counted from 0) is lit only when s < bright. A lit step drives the enable of the current digit and its pattern. An unlit step drives all lines inactive. bright = 0 keeps the display dark.
- R5: The last step of every slot is always dark, whatever the brightness or mode.
- R6: Segment bits of seg_out are mapped as bit 0 = a (top), going clockwise through bit 5 = f, then bit 6 = g (centre) and bit 7 = decimal point. Codes 0–9 give the standard decimal glyphs. The decimal point follows the held dp bit of the lit digit.
- R7: Codes 10 to 15 light none of a–g. The decimal point still follows its held bit.
- R8: While lamp_test_n is low, all eight segment lines are active during steps 0 to 2^BRIGHT_W-2 of every slot, with the scanned digit enabled. This ignores bright, the held data and blank_n.
- R9: While blank_n is low and lamp_test_n is high, all segment and enable lines are inactive.
- R10: With COMMON_ANODE = 0 the active level is high. With COMMON_ANODE = 1 both seg_out and dig_en are the bitwise inverse of the COMMON_ANODE = 0 result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| digits_in | input | NDIG*4 | BCD codes; digit i is in bits 4i+3:4i |
| dp_in | input | NDIG | Decimal point per digit |
| load_stb | input | 1 | Copies digits_in and dp_in into the hold register |
| lamp_test_n | input | 1 | Active-low all-segments-on override |
| blank_n | input | 1 | Active-low display-off override |
| bright | input | BRIGHT_W | Number of lit steps per slot |
| seg_out | output | 8 | Shared segment lines: a..g in bits 0..6, decimal point in bit 7 |
| dig_en | output | NDIG | Per-digit common-electrode enables |

## Verification
If the scan counters go wrong, the fault shows at the ports within one slot. The enable moves to the wrong digit, or the lit window has the wrong length. The bench compares every cycle against a model of the scan position, so such a fault is caught on the very next edge. A wrong hold register or a wrong decode shows only while the affected digit is lit. The bench therefore runs at least one full frame after every load, and loads every code into every digit position. An override stuck in the wrong state corrupts every lit step. The lamp-test check uses bright = 0 and blank_n low, so that both priority rules and the independence from brightness are visible within the first slot.

// File: rtl/seg7_pkg.sv
package seg7_pkg;

    typedef logic [3:0] bcd_t;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_BLANK  = 2'd1,
        MODE_LAMP   = 2'd2
    } disp_mode_t;

    // Bit 0 = a (top), clockwise through f, bit 6 = g (centre), bit 7 = dp
    typedef struct packed {
        logic       dp;
        logic [6:0] seg;
    } glyph_t;

    localparam glyph_t GLYPH_OFF = '{dp: 1'b0, seg: 7'h00};
    localparam glyph_t GLYPH_ALL = '{dp: 1'b1, seg: 7'h7F};

    function automatic logic [6:0] bcd_to_seg(input bcd_t code);
        logic [6:0] s;
        case (code)
            4'd0:    s = 7'h3F;
            4'd1:    s = 7'h06;
            4'd2:    s = 7'h5B;
            4'd3:    s = 7'h4F;
            4'd4:    s = 7'h66;
            4'd5:    s = 7'h6D;
            4'd6:    s = 7'h7D;
            4'd7:    s = 7'h07;
            4'd8:    s = 7'h7F;
            4'd9:    s = 7'h6F;
            default: s = 7'h00;
        endcase
        return s;
    endfunction

    // Lamp test outranks blanking
    function automatic disp_mode_t pick_mode(input logic lamp_n, input logic blank_n);
        disp_mode_t m;
        if (!lamp_n)       m = MODE_LAMP;
        else if (!blank_n) m = MODE_BLANK;
        else               m = MODE_NORMAL;
        return m;
    endfunction

endpackage

// File: rtl/seg_latch.sv
module seg_latch
    import seg7_pkg::*;
#(
    parameter int NDIG = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [NDIG*4-1:0]   digits_in,
    input  logic [NDIG-1:0]     dp_in,
    output logic [NDIG*4-1:0]   held_digits,
    output logic [NDIG-1:0]     held_dp
);

    always_ff @(posedge clk) begin
        if (rst) begin
            held_digits <= '1;
            held_dp     <= '0;
        end else if (load) begin
            held_digits <= digits_in;
            held_dp     <= dp_in;
        end
    end

    // R2
    hold_without_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(held_digits) && $stable(held_dp)));

    // R2
    load_copies_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (held_digits == $past(digits_in) && held_dp == $past(dp_in)));

endmodule

// File: rtl/seg_scan_timer.sv
module seg_scan_timer #(
    parameter int NDIG     = 4,
    parameter int STEP_CYC = 2,
    parameter int BRIGHT_W = 2,
    localparam int DW      = (NDIG > 1) ? $clog2(NDIG) : 1,
    localparam int SCW     = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1
) (
    input  logic                clk,
    input  logic                rst,
    output logic [DW-1:0]       dig_idx,
    output logic [BRIGHT_W-1:0] step_idx
);

    localparam logic [SCW-1:0]      STEP_LAST = SCW'(STEP_CYC - 1);
    localparam logic [DW-1:0]       DIG_LAST  = DW'(NDIG - 1);
    localparam logic [BRIGHT_W-1:0] SLOT_LAST = '1;

    logic [SCW-1:0] step_cnt;
    logic           step_end;
    logic           slot_end;

    assign step_end = (step_cnt == STEP_LAST);
    assign slot_end = step_end && (step_idx == SLOT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            step_cnt <= '0;
            step_idx <= '0;
            dig_idx  <= '0;
        end else begin
            if (step_end) begin
                step_cnt <= '0;
                step_idx <= step_idx + 1'b1;
            end else begin
                step_cnt <= step_cnt + 1'b1;
            end
            if (slot_end) begin
                dig_idx <= (dig_idx == DIG_LAST) ? '0 : dig_idx + 1'b1;
            end
        end
    end

    // R3
    dig_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        dig_idx <= DIG_LAST);

    // R3
    dig_stays_in_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (step_idx != SLOT_LAST) |=> $stable(dig_idx));

endmodule

// File: rtl/seg_pattern.sv
module seg_pattern
    import seg7_pkg::*;
#(
    parameter int NDIG     = 4,
    parameter int BRIGHT_W = 2,
    localparam int DW      = (NDIG > 1) ? $clog2(NDIG) : 1
) (
    input  logic [NDIG*4-1:0]   held_digits,
    input  logic [NDIG-1:0]     held_dp,
    input  logic [DW-1:0]       dig_idx,
    input  logic [BRIGHT_W-1:0] step_idx,
    input  logic [BRIGHT_W-1:0] bright,
    input  logic                lamp_n,
    input  logic                blank_n,
    output glyph_t              glyph_act,
    output logic [NDIG-1:0]     en_act
);

    localparam logic [BRIGHT_W-1:0] SLOT_LAST = '1;

    bcd_t       code_arr [NDIG];
    glyph_t     normal_glyph;
    disp_mode_t mode;
    logic       lit;

    for (genvar i = 0; i < NDIG; i++) begin : g_unpack
        assign code_arr[i] = held_digits[i*4 +: 4];
    end

    assign mode = pick_mode(lamp_n, blank_n);

    always_comb begin
        normal_glyph.seg = bcd_to_seg(code_arr[dig_idx]);
        normal_glyph.dp  = held_dp[dig_idx];
    end

    always_comb begin
        unique case (mode)
            MODE_LAMP:   lit = (step_idx != SLOT_LAST);
            MODE_BLANK:  lit = 1'b0;
            default:     lit = (step_idx < bright);
        endcase
    end

    always_comb begin
        en_act    = '0;
        glyph_act = GLYPH_OFF;
        if (lit) begin
            en_act[dig_idx] = 1'b1;
            glyph_act       = (mode == MODE_LAMP) ? GLYPH_ALL : normal_glyph;
        end
    end

endmodule

// File: rtl/seg_mux_display.sv
module seg_mux_display
    import seg7_pkg::*;
#(
    parameter int NDIG         = 4,
    parameter int STEP_CYC     = 3125,
    parameter int BRIGHT_W     = 4,
    parameter bit COMMON_ANODE = 1'b0,
    localparam int DW          = (NDIG > 1) ? $clog2(NDIG) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NDIG*4-1:0]   digits_in,
    input  logic [NDIG-1:0]     dp_in,
    input  logic                load_stb,
    input  logic                lamp_test_n,
    input  logic                blank_n,
    input  logic [BRIGHT_W-1:0] bright,
    output logic [7:0]          seg_out,
    output logic [NDIG-1:0]     dig_en
);

    localparam logic [BRIGHT_W-1:0] SLOT_LAST = '1;

    logic [NDIG*4-1:0]   held_digits;
    logic [NDIG-1:0]     held_dp;
    logic [DW-1:0]       dig_idx;
    logic [BRIGHT_W-1:0] step_idx;
    glyph_t              glyph_act;
    logic [NDIG-1:0]     en_act;
    glyph_t              glyph_q;
    logic [NDIG-1:0]     en_q;

    seg_latch #(.NDIG(NDIG)) u_latch (
        .clk         (clk),
        .rst         (rst),
        .load        (load_stb),
        .digits_in   (digits_in),
        .dp_in       (dp_in),
        .held_digits (held_digits),
        .held_dp     (held_dp)
    );

    seg_scan_timer #(.NDIG(NDIG), .STEP_CYC(STEP_CYC), .BRIGHT_W(BRIGHT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .dig_idx  (dig_idx),
        .step_idx (step_idx)
    );

    seg_pattern #(.NDIG(NDIG), .BRIGHT_W(BRIGHT_W)) u_pattern (
        .held_digits (held_digits),
        .held_dp     (held_dp),
        .dig_idx     (dig_idx),
        .step_idx    (step_idx),
        .bright      (bright),
        .lamp_n      (lamp_test_n),
        .blank_n     (blank_n),
        .glyph_act   (glyph_act),
        .en_act      (en_act)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            glyph_q <= GLYPH_OFF;
            en_q    <= '0;
        end else begin
            glyph_q <= glyph_act;
            en_q    <= en_act;
        end
    end

    if (COMMON_ANODE) begin : g_anode
        assign seg_out = ~glyph_q;
        assign dig_en  = ~en_q;
    end else begin : g_cathode
        assign seg_out = glyph_q;
        assign dig_en  = en_q;
    end

    // R3
    single_digit_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(en_q));

    // R5
    last_step_dark_chk: assert property (@(posedge clk) disable iff (rst)
        (step_idx == SLOT_LAST) |=> (en_q == '0 && glyph_q == GLYPH_OFF));

    // R9
    blank_dark_chk: assert property (@(posedge clk) disable iff (rst)
        (!blank_n && lamp_test_n) |=> (en_q == '0 && glyph_q == GLYPH_OFF));

    // R8
    lamp_all_on_chk: assert property (@(posedge clk) disable iff (rst)
        (!lamp_test_n && step_idx != SLOT_LAST) |=> (glyph_q == GLYPH_ALL && $onehot(en_q)));

    // R4
    zero_bright_dark_chk: assert property (@(posedge clk) disable iff (rst)
        (lamp_test_n && bright == '0) |=> (en_q == '0));

endmodule

// File: tb/seg_mux_display_test.sv
module seg_mux_display_test;

    localparam int ND   = 4;
    localparam int SC   = 2;
    localparam int BW   = 2;
    localparam int STEPS = 1 << BW;
    localparam int SLOT  = STEPS * SC;
    localparam int FRAME = SLOT * ND;

    logic          clk = 1'b0;
    logic          rst;
    logic [ND*4-1:0] digits_in;
    logic [ND-1:0] dp_in;
    logic          load_stb;
    logic          lamp_test_n;
    logic          blank_n;
    logic [BW-1:0] bright;
    logic [7:0]    seg_out, seg_out_ca;
    logic [ND-1:0] dig_en, dig_en_ca;

    int checks = 0;
    int errors = 0;
    int n_adv = 0;
    logic [ND*4-1:0] m_lat;
    logic [ND-1:0]   m_dp;
    logic [7:0]      exp_seg;
    logic [ND-1:0]   exp_en;
    int lit_cycles;

    always #10 clk = ~clk;

    seg_mux_display #(.NDIG(ND), .STEP_CYC(SC), .BRIGHT_W(BW), .COMMON_ANODE(1'b0)) uut (
        .clk(clk), .rst(rst), .digits_in(digits_in), .dp_in(dp_in), .load_stb(load_stb),
        .lamp_test_n(lamp_test_n), .blank_n(blank_n), .bright(bright),
        .seg_out(seg_out), .dig_en(dig_en)
    );

    seg_mux_display #(.NDIG(ND), .STEP_CYC(SC), .BRIGHT_W(BW), .COMMON_ANODE(1'b1)) uut_ca (
        .clk(clk), .rst(rst), .digits_in(digits_in), .dp_in(dp_in), .load_stb(load_stb),
        .lamp_test_n(lamp_test_n), .blank_n(blank_n), .bright(bright),
        .seg_out(seg_out_ca), .dig_en(dig_en_ca)
    );

    // Segment membership per decimal digit, a..g
    function automatic logic [6:0] ref_seg(input int d);
        logic [6:0] r;
        if (d > 9) return 7'h00;
        r[0] = d inside {0, 2, 3, 5, 6, 7, 8, 9};
        r[1] = d inside {0, 1, 2, 3, 4, 7, 8, 9};
        r[2] = d inside {0, 1, 3, 4, 5, 6, 7, 8, 9};
        r[3] = d inside {0, 2, 3, 5, 6, 8, 9};
        r[4] = d inside {0, 2, 6, 8};
        r[5] = d inside {0, 4, 5, 6, 8, 9};
        r[6] = d inside {2, 3, 4, 5, 6, 8, 9};
        return r;
    endfunction

    task automatic model_next();
        int dg, st;
        logic lit;
        exp_seg = 8'h00;
        exp_en  = '0;
        if (!rst) begin
            dg = (n_adv / SLOT) % ND;
            st = (n_adv / SC) % STEPS;
            if (!lamp_test_n) begin
                lit = (st < STEPS - 1);
                exp_seg = 8'hFF;
            end else if (!blank_n) begin
                lit = 1'b0;
            end else begin
                lit = (st < int'(bright));
                exp_seg = {m_dp[dg], ref_seg(int'(m_lat[dg*4 +: 4]))};
            end
            if (lit) exp_en = ND'(1) << dg;
            else     exp_seg = 8'h00;
            n_adv++;
            if (load_stb) begin
                m_lat = digits_in;
                m_dp  = dp_in;
            end
        end else begin
            n_adv = 0;
            m_lat = '1;
            m_dp  = '0;
        end
    endtask

    task automatic tick(input string tag);
        model_next();
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (seg_out !== exp_seg || dig_en !== exp_en) begin
            errors++;
            $display("FAIL %s: seg=%h en=%b expected seg=%h en=%b (n=%0d)",
                     tag, seg_out, dig_en, exp_seg, exp_en, n_adv);
        end
        checks++;
        if (seg_out_ca !== ~seg_out || dig_en_ca !== ~dig_en) begin
            errors++;
            $display("FAIL R10: anode seg=%h en=%b expected seg=%h en=%b",
                     seg_out_ca, dig_en_ca, ~seg_out, ~dig_en);
        end
        if (|dig_en) lit_cycles++;
    endtask

    task automatic run(input int cyc, input string tag);
        for (int i = 0; i < cyc; i++) tick(tag);
    endtask

    task automatic load(input logic [ND*4-1:0] d, input logic [ND-1:0] p, input string tag);
        digits_in = d;
        dp_in     = p;
        load_stb  = 1'b1;
        tick(tag);
        load_stb  = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; digits_in = '0; dp_in = '0; load_stb = 1'b0;
        lamp_test_n = 1'b1; blank_n = 1'b1; bright = '1;
        @(negedge clk);
        // R1: reset state, including first edge after release
        run(3, "R1");
        rst = 1'b0;
        run(FRAME, "R1 reset latch shows code 15 dark");

        // R3 R6: scan order and glyphs
        load(16'h3210, 4'b0101, "R6");
        run(2 * FRAME, "R3 R6 scan");

        // R6 R7: every code in every position
        for (int rot = 0; rot < ND; rot++) begin
            for (int grp = 0; grp < 4; grp++) begin
                logic [ND*4-1:0] w;
                for (int k = 0; k < ND; k++) w[k*4 +: 4] = 4'((grp * 4 + ((k + rot) % ND)));
                load(w, 4'(grp + rot), "R7");
                run(FRAME, "R6 R7 code sweep");
            end
        end

        // R4 R5: brightness sweep with lit-cycle totals
        load(16'h8888, 4'b1111, "R4");
        for (int b = 0; b < STEPS; b++) begin
            bright = BW'(b);
            run(FRAME, "R4 R5 bright");
            lit_cycles = 0;
            run(FRAME, "R4 R5 bright");
            checks++;
            if (lit_cycles != ND * b * SC) begin
                errors++;
                $display("FAIL R4: lit cycles %0d expected %0d", lit_cycles, ND * b * SC);
            end
        end
        bright = '1;

        // R2: data changes without strobe do not reach the display
        digits_in = 16'h1111; dp_in = 4'b0000;
        run(FRAME, "R2 no strobe");
        digits_in = 16'h7777; dp_in = 4'b1010;
        run(FRAME, "R2 no strobe");
        load(16'h9051, 4'b0010, "R2 strobe");
        run(FRAME, "R2 after strobe");

        // R9: blanking
        blank_n = 1'b0;
        run(FRAME, "R9 blank");
        // R8: lamp test outranks blank, ignores bright
        bright = '0;
        lamp_test_n = 1'b0;
        run(FRAME, "R8 lamp over blank");
        blank_n = 1'b1;
        run(FRAME, "R8 lamp");
        lamp_test_n = 1'b1;
        bright = 2'd2;
        run(FRAME, "R4 after lamp");

        // R1: reset mid-scan
        rst = 1'b1;
        run(2, "R1 mid reset");
        rst = 1'b0;
        run(FRAME, "R1 after mid reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule